// File: doc/BRIEF.md
# Serial Port Buffer Status and Interrupt Controller

This block keeps the status flags and the interrupt request for a double-buffered synchronous serial port. Software places a word in a transmit holding buffer. The block moves it into a shift register as soon as that register is idle. It then shifts the frame out most-significant bit first and samples the incoming line into the same register. Completed receive frames go into a receive holding buffer. The frame length is set by a 4-bit field and covers 1 to 16 bits.

Four flags come out of this traffic: transmit buffer empty, receive buffer full, end of transmission and overrun. They do not share one clear method. Two are cleared as a side effect of a data access: writing transmit data or reading receive data. The other two are cleared only by writing a 1 to them. A per-flag enable mask combines the flags into a single level interrupt. Two busy outputs report shifter activity and memory-mapped access activity.

Top module: `sbuf_irq_ctrl`

## Requirements
- R1: After synchronous reset, all four flags, all four enables, the interrupt output and both busy outputs are 0.
- R2: A frame length setting of L makes every frame exactly L+1 bits long. Bits leave on `sdo`, most-significant first, starting from bit L of the transmit word. One bit is shifted on each cycle where `bit_en` is high. The received word is right-aligned, and the bits above bit L are zero.
- R3: Flag bit 0 (transmit buffer empty) sets in the cycle after a buffered word is loaded into the idle shift register. It clears on the cycle after a write to the transmit data port.
- R4: Flag bit 2 (end of transmission) sets when a frame completes while bit 0 is 1. It stays 0 if bit 0 is 0 because another word is waiting. It clears only through write-one-to-clear.
- R5: Flag bit 1 (receive buffer full) sets when a completed frame is moved into the receive buffer, and `rxd_rdata` then shows that frame. Bit 1 clears on the cycle after a receive-data read.
- R6: Flag bit 3 (overrun) sets when a frame completes while bit 1 is 1 and no read happens in that cycle. In that case the receive buffer keeps its old word and the new frame is dropped.
- R7: A write-one-to-clear with a 0 in a bit leaves that flag unchanged. When a set event and a clear of bit 2 or bit 3 happen in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while some flag bit and the matching `ien` bit are both 1.
- R9: `busy_reg` rises in the cycle after a transmit word is loaded into the shift register. It falls after the last bit of that frame is shifted. With `bit_en` held high, it stays high for exactly L+1 cycles.
- R10: `busy_mm` follows `mm_active` with a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_len | input | 4 | Frame length setting, giving length+1 bits per frame |
| bit_en | input | 1 | Shift enable, one bit per high cycle |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| txd_wr | input | 1 | Transmit data write strobe |
| txd_wdata | input | 16 | Transmit data |
| rxd_rd | input | 1 | Receive data read strobe |
| rxd_rdata | output | 16 | Receive buffer contents |
| clr_wr | input | 1 | Write-one-to-clear strobe for the flags |
| clr_data | input | 4 | Clear mask: bit 2 is end of transmission, bit 3 is overrun |
| ien_wr | input | 1 | Enable mask write strobe |
| ien_data | input | 4 | Enable mask value |
| ien | output | 4 | Current enable mask |
| flags | output | 4 | bit0 transmit empty, bit1 receive full, bit2 end of transmission, bit3 overrun |
| irq | output | 1 | Interrupt request level |
| mm_active | input | 1 | Activity signal from the memory-mapped engine |
| busy_reg | output | 1 | Register-access busy |
| busy_mm | output | 1 | Memory-mapped access busy |

## Verification
A wrong bit counter changes the number of cycles `busy_reg` stays high and the number of bits received. Both show up at the end of the first frame. A wrong transmit-empty state shows up the next time end of transmission is or is not raised. A receive buffer that gets overwritten on overrun shows a new value on `rxd_rdata` one cycle after the second frame completes. Flag-clear and enable mistakes show up at `flags` or `irq` one cycle after the write.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;

    typedef struct packed {
        logic oe;
        logic tend;
        logic rbf;
        logic tbe;
    } flag_t;

    localparam int F_TBE  = 0;
    localparam int F_RBF  = 1;
    localparam int F_TEND = 2;
    localparam int F_OE   = 3;

    // bits 0..len set, rest clear
    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i <= int'(len));
        end
        return m;
    endfunction

endpackage

// File: rtl/sbuf_shifter.sv
module sbuf_shifter
    import sbuf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] frame_len,
    input  logic          bit_en,
    input  logic          sdi,
    output logic          sdo,
    input  logic          txd_wr,
    input  logic [DW-1:0] txd_wdata,
    output logic          load_evt,
    output logic          done_evt,
    output logic [DW-1:0] rx_word,
    output logic          active
);

    logic [DW-1:0] tx_buf;
    logic          tx_full;
    logic [DW-1:0] shreg;
    logic [LW-1:0] cnt;

    assign load_evt = tx_full && !active;
    assign done_evt = active && bit_en && (cnt == frame_len);
    assign sdo      = active && shreg[frame_len];
    assign rx_word  = {shreg[DW-2:0], sdi} & len_mask(frame_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
            active  <= 1'b0;
        end else begin
            if (txd_wr) begin
                tx_buf  <= txd_wdata;
                tx_full <= 1'b1;
            end else if (load_evt) begin
                tx_full <= 1'b0;
            end

            if (load_evt) begin
                shreg  <= tx_buf;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active && bit_en) begin
                shreg <= {shreg[DW-2:0], sdi};
                cnt   <= cnt + 1'b1;
                if (done_evt) active <= 1'b0;
            end
        end
    end

    a_r9_load_busy: assert property (@(posedge clk) disable iff (rst)
        load_evt |=> active);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !active);
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (active && $stable(frame_len)) |-> (cnt <= frame_len));

endmodule

// File: rtl/sbuf_flags.sv
module sbuf_flags
    import sbuf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_evt,
    input  logic          done_evt,
    input  logic [DW-1:0] rx_word,
    input  logic          txd_wr,
    input  logic          rxd_rd,
    input  logic          clr_wr,
    input  logic [3:0]    clr_data,
    input  logic          ien_wr,
    input  logic [3:0]    ien_data,
    output flag_t         flg,
    output logic [3:0]    ien_q,
    output logic [DW-1:0] rx_data,
    output logic          irq
);

    logic rx_take;
    logic w1c_tend;
    logic w1c_oe;

    // new frame is kept if the buffer is free or freed this cycle
    assign rx_take  = done_evt && (!flg.rbf || rxd_rd);
    assign w1c_tend = clr_wr && clr_data[F_TEND];
    assign w1c_oe   = clr_wr && clr_data[F_OE];
    assign irq      = |(flg & ien_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg     <= '0;
            ien_q   <= '0;
            rx_data <= '0;
        end else begin
            if (load_evt)    flg.tbe <= 1'b1;
            else if (txd_wr) flg.tbe <= 1'b0;

            if (done_evt)    flg.rbf <= 1'b1;
            else if (rxd_rd) flg.rbf <= 1'b0;

            if (rx_take) rx_data <= rx_word;

            if (done_evt && flg.tbe) flg.tend <= 1'b1;
            else if (w1c_tend)       flg.tend <= 1'b0;

            if (done_evt && flg.rbf && !rxd_rd) flg.oe <= 1'b1;
            else if (w1c_oe)                    flg.oe <= 1'b0;

            if (ien_wr) ien_q <= ien_data;
        end
    end

    a_r8_masked: assert property (@(posedge clk) disable iff (rst)
        (ien_q == 4'b0) |-> !irq);
    a_r3_tbe_set: assert property (@(posedge clk) disable iff (rst)
        load_evt |=> flg.tbe);
    a_r5_rbf_clear: assert property (@(posedge clk) disable iff (rst)
        (rxd_rd && !done_evt) |=> !flg.rbf);
    a_r6_keep_old: assert property (@(posedge clk) disable iff (rst)
        (done_evt && flg.rbf && !rxd_rd) |=> (flg.oe && $stable(rx_data)));
    a_r7_oe_sticky: assert property (@(posedge clk) disable iff (rst)
        (flg.oe && !w1c_oe) |=> flg.oe);

endmodule

// File: rtl/sbuf_irq_ctrl.sv
module sbuf_irq_ctrl
    import sbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              bit_en,
    input  logic              sdi,
    output logic              sdo,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_wdata,
    input  logic              rxd_rd,
    output logic [DATA_W-1:0] rxd_rdata,
    input  logic              clr_wr,
    input  logic [3:0]        clr_data,
    input  logic              ien_wr,
    input  logic [3:0]        ien_data,
    output logic [3:0]        ien,
    output logic [3:0]        flags,
    output logic              irq,
    input  logic              mm_active,
    output logic              busy_reg,
    output logic              busy_mm
);

    logic              load_evt;
    logic              done_evt;
    logic [DATA_W-1:0] rx_word;
    flag_t             flg;

    sbuf_shifter #(.DW(DATA_W), .LW(LEN_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .frame_len (frame_len),
        .bit_en    (bit_en),
        .sdi       (sdi),
        .sdo       (sdo),
        .txd_wr    (txd_wr),
        .txd_wdata (txd_wdata),
        .load_evt  (load_evt),
        .done_evt  (done_evt),
        .rx_word   (rx_word),
        .active    (busy_reg)
    );

    sbuf_flags #(.DW(DATA_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .load_evt (load_evt),
        .done_evt (done_evt),
        .rx_word  (rx_word),
        .txd_wr   (txd_wr),
        .rxd_rd   (rxd_rd),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .ien_wr   (ien_wr),
        .ien_data (ien_data),
        .flg      (flg),
        .ien_q    (ien),
        .rx_data  (rxd_rdata),
        .irq      (irq)
    );

    assign flags = flg;

    always_ff @(posedge clk) begin
        if (rst) busy_mm <= 1'b0;
        else     busy_mm <= mm_active;
    end

    a_r10_mm_follow: assert property (@(posedge clk) disable iff (rst)
        mm_active |=> busy_mm);

endmodule

// File: tb/tb_sbuf_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sbuf_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  frame_len;
    logic        bit_en;
    logic        sdi;
    logic        sdo;
    logic        txd_wr;
    logic [15:0] txd_wdata;
    logic        rxd_rd;
    logic [15:0] rxd_rdata;
    logic        clr_wr;
    logic [3:0]  clr_data;
    logic        ien_wr;
    logic [3:0]  ien_data;
    logic [3:0]  ien;
    logic [3:0]  flags;
    logic        irq;
    logic        mm_active;
    logic        busy_reg;
    logic        busy_mm;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;
    assign sdi = sdo; // loopback

    sbuf_irq_ctrl dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] msk(input int len);
        logic [16:0] m;
        m = (17'd1 << (len + 1)) - 17'd1;
        return m[15:0];
    endfunction

    task automatic pulse_clr(input logic [3:0] m);
        @(negedge clk); clr_wr = 1'b1; clr_data = m;
        @(negedge clk); clr_wr = 1'b0; clr_data = 4'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rxd_rd = 1'b1;
        @(negedge clk); rxd_rd = 1'b0;
    endtask

    task automatic set_ien(input logic [3:0] m);
        @(negedge clk); ien_wr = 1'b1; ien_data = m;
        @(negedge clk); ien_wr = 1'b0;
    endtask

    // write a word, follow the frame, optionally hit W1C on the done edge
    task automatic send(input int len, input logic [15:0] w, input bit clr_end,
                        output int nbits, output logic [15:0] cap);
        bit seen = 0;
        nbits = 0; cap = '0;
        @(negedge clk); frame_len = len[3:0]; txd_wr = 1'b1; txd_wdata = w;
        @(negedge clk); txd_wr = 1'b0;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            clr_wr = 1'b0; clr_data = 4'b0;
            if (busy_reg) begin
                seen = 1; nbits++;
                cap = {cap[14:0], sdo};
                if (clr_end && nbits == len + 1) begin
                    clr_wr = 1'b1; clr_data = 4'b0100;
                end
            end else if (seen) begin
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", "flags", flags, 0);
        chk("R1", "ien", ien, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "busy_reg", busy_reg, 0);
        chk("R1", "busy_mm", busy_mm, 0);
    endtask

    task automatic t_frame(input int len, input logic [15:0] w);
        int n; logic [15:0] c;
        send(len, w, 0, n, c);
        chk("R9", "busy cycles", n, len + 1);
        chk("R2", "sdo bits", c & msk(len), w & msk(len));
        chk("R5", "rx word", rxd_rdata, w & msk(len));
        chk("R3", "tbe after load", flags[0], 1);
        chk("R5", "rbf set", flags[1], 1);
        chk("R4", "tend set", flags[2], 1);
        pulse_rd();
        chk("R5", "rbf cleared by read", flags[1], 0);
        pulse_clr(4'b0100);
        chk("R4", "tend W1C", flags[2], 0);
    endtask

    task automatic t_overrun();
        int n; logic [15:0] c;
        send(7, 16'h005A, 0, n, c);
        send(7, 16'h00C3, 0, n, c);
        chk("R6", "oe set", flags[3], 1);
        chk("R6", "old word kept", rxd_rdata, 16'h005A);
        pulse_clr(4'b0000);
        chk("R7", "oe kept on zero write", flags[3], 1);
        pulse_clr(4'b0100);
        chk("R7", "oe kept on other bit", flags[3], 1);
        pulse_clr(4'b1000);
        chk("R7", "oe W1C", flags[3], 0);
        pulse_rd();
        pulse_clr(4'b0100);
        chk("R5", "rbf clear", flags[1], 0);
    endtask

    task automatic t_back2back();
        @(negedge clk); frame_len = 4'd7; txd_wr = 1'b1; txd_wdata = 16'h0011;
        @(negedge clk); txd_wr = 1'b0;
        @(negedge clk);
        chk("R3", "tbe on load", flags[0], 1);
        chk("R9", "busy on load", busy_reg, 1);
        txd_wr = 1'b1; txd_wdata = 16'h0022;
        @(negedge clk); txd_wr = 1'b0;
        chk("R3", "tbe cleared by write", flags[0], 0);
        for (int g = 0; g < 50 && busy_reg; g++) @(negedge clk);
        chk("R4", "no tend with word pending", flags[2], 0);
        chk("R5", "first word", rxd_rdata, 16'h0011);
        rxd_rd = 1'b1;
        @(negedge clk); rxd_rd = 1'b0;
        for (int g = 0; g < 50 && busy_reg; g++) @(negedge clk);
        chk("R4", "tend after last word", flags[2], 1);
        chk("R5", "second word", rxd_rdata, 16'h0022);
        chk("R6", "no overrun", flags[3], 0);
        pulse_rd();
        pulse_clr(4'b0100);
    endtask

    task automatic t_set_wins();
        int n; logic [15:0] c;
        send(4, 16'h0013, 1, n, c);
        chk("R7", "set beats clear", flags[2], 1);
        pulse_rd();
    endtask

    task automatic t_irq();
        // flags now: tbe=1, rbf=0, tend=1, oe=0
        chk("R8", "no enables", irq, 0);
        set_ien(4'b1010);
        chk("R8", "enabled flags clear", irq, 0);
        set_ien(4'b0100);
        chk("R8", "tend enabled", irq, 1);
        pulse_clr(4'b0100);
        chk("R8", "after tend cleared", irq, 0);
        set_ien(4'b0001);
        chk("R8", "tbe enabled", irq, 1);
        set_ien(4'b0000);
    endtask

    task automatic t_mm();
        @(negedge clk); mm_active = 1'b1;
        chk("R10", "not yet", busy_mm, 0);
        @(negedge clk); mm_active = 1'b0;
        chk("R10", "follows", busy_mm, 1);
        @(negedge clk);
        chk("R10", "drops", busy_mm, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_len = 4'd7; bit_en = 1'b1;
        txd_wr = 1'b0; txd_wdata = '0; rxd_rd = 1'b0;
        clr_wr = 1'b0; clr_data = '0; ien_wr = 1'b0; ien_data = '0;
        mm_active = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(15, 16'hC3A5);
        t_frame(3, 16'hFFF6);
        t_frame(0, 16'h0001);
        t_overrun();
        t_back2back();
        t_set_wins();
        t_irq();
        t_mm();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule